// File: doc/BRIEF.md
# Two-stage watchdog timer

This block is a memory-mapped watchdog with two cascaded countdowns. When it is enabled, the first stage counts down a software preload. When that stage runs out it can latch a level interrupt. The second stage then loads its own preload and counts down. If software has not restarted the count before the second stage runs out, the block emits a one-cycle reset request and records the event in a sticky flag. That flag survives the system reset the request causes.

A two-write magic sequence guards the preload registers and the restart/flag-clear control. After software writes 0x80 and then 0x86 to the control word, exactly one protected write is accepted. A separate configuration word chooses the tick rate, the interrupt behaviour and whether the reset request is driven. A separate lock word holds the mode, enable and lock bits. Once set, the lock freezes that word until a hardware reset. The tick is derived from an input clock-enable through a power-of-two prescaler. The two division ratios are parameters.

Top module: `wdog2s`

## Requirements
- R1: After power-on reset (`por_n` low) every readable register reads 0, and `irq` and `rst_req` are 0.
- R2: A write to a protected location without a completed unlock leaves it unchanged. The protected locations are preload-1 (0x00), preload-2 (0x04) and the control word (0x0C, apart from the magic values).
- R3: Writing 0x80 and then 0x86 (low 16 data bits) to 0x0C unlocks the protected locations. Exactly the next protected write is accepted, and any protected write after that is ignored again.
- R4: Any bus write directly after 0x80, other than 0x86 to 0x0C, cancels the unlock sequence. This includes a write to an unprotected register.
- R5: Preload-1 (0x00) and preload-2 (0x04) hold 20 bits each. Upper bits read as 0.
- R6: An accepted control write with bit 8 set restarts stage 1 from preload-1 and clears the prescaler. A restart in the same cycle as an expiry wins, so that expiry does not happen.
- R7: Lock-word bit 1 (0x14) enables counting. Stage 1 expires after max(P1,1) ticks and stage 2 after a further max(P2,1) ticks. A tick occurs every 2^SLOW_LOG2 `tick_en` pulses when configuration bit 2 (0x10) is 0, and every 2^FAST_LOG2 pulses when it is 1.
- R8: A stage-1 expiry sets status bit 0 (0x08) and drives `irq` high unless configuration bits 1:0 are 11. Writing 1 to status bit 0 clears it. A set in the same cycle as a clear wins.
- R9: In watchdog mode (lock bit 2 = 0), a stage-2 expiry sets control bit 9 (0x0C). With configuration bit 5 = 0 it also pulses `rst_req` high for exactly one cycle.
- R10: Configuration bit 5 = 1 suppresses `rst_req`, while bit 9 is still set.
- R11: Control bit 9 stays set through `sys_rst_n`. It is cleared only by `por_n` or by an accepted control write with bit 9 set.
- R12: Once lock bit 0 is set, writes to the lock word are ignored until a reset, and the enable bit keeps reading 1.
- R13: In timer mode (lock bit 2 = 1), a stage-2 expiry restarts stage 1 without `rst_req` and without setting bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low, synchronous, clears everything |
| sys_rst_n | input | 1 | System reset, active low, synchronous, keeps the timeout flag |
| tick_en | input | 1 | Prescaler clock-enable pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Stage-1 interrupt, level until cleared |
| rst_req | output | 1 | One-cycle reset request on stage-2 expiry |

## Verification
Two pairs of events can land on the same clock edge. In the first pair, a stage-1 expiry meets a software write that clears the interrupt status. In the second pair, a tick that would expire a stage meets an accepted restart. The bench counts cycles from the enabling write and times its writes so that they commit on the exact edge of the predicted expiry. It then judges the outcome at the next falling edge. The interrupt must stay set in the first case, and the restart must suppress the expiry in the second, with the interrupt appearing one full stage-1 period later.

// File: rtl/wdog2s.sv
module wdog2s #(
  parameter int PRE_W     = 20,
  parameter int SLOW_LOG2 = 15,
  parameter int FAST_LOG2 = 5
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        sys_rst_n,
  input  logic        tick_en,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq,
  output logic        rst_req
);
  localparam int PW = (SLOW_LOG2 > FAST_LOG2) ? SLOW_LOG2 : FAST_LOG2;
  localparam logic [PW-1:0] MASK_S = PW'((33'd1 << SLOW_LOG2) - 33'd1);
  localparam logic [PW-1:0] MASK_F = PW'((33'd1 << FAST_LOG2) - 33'd1);

  logic [PRE_W-1:0] pre1, pre2, cnt;
  logic [PW-1:0]    pcnt;
  logic [1:0]       ust;
  logic             stage, int_flag, tflag;
  logic             cfg_rst, cfg_fast;
  logic [1:0]       cfg_it;
  logic             lk, en, mode;

  wire rst_i   = !por_n || !sys_rst_n;
  wire wr_pre1 = wr_en && addr == 8'h00;
  wire wr_pre2 = wr_en && addr == 8'h04;
  wire wr_stat = wr_en && addr == 8'h08;
  wire wr_rld  = wr_en && addr == 8'h0C;
  wire wr_cfg  = wr_en && addr == 8'h10;
  wire wr_lock = wr_en && addr == 8'h14;
  wire open_w  = ust == 2'd2;
  wire magic1  = wdata[15:0] == 16'h0080;
  wire magic2  = wdata[15:0] == 16'h0086;
  wire rld_acc = wr_rld && open_w;
  wire reload  = rld_acc && wdata[8];

  wire [PW-1:0] pmask = cfg_fast ? MASK_F : MASK_S;
  wire tick    = en && tick_en && ((pcnt & pmask) == pmask);
  wire expire  = tick && !reload && (cnt <= PRE_W'(1));
  wire s1_exp  = expire && !stage;
  wire s2_exp  = expire && stage;
  wire wd_mode = !mode;

  logic unused_bits;
  assign unused_bits = ^wdata;

  always_ff @(posedge clk) begin
    if (rst_i) ust <= 2'd0;
    else if (wr_en) begin
      if (open_w) begin
        if (wr_pre1 || wr_pre2 || wr_rld) ust <= 2'd0;
      end else if (wr_rld)
        ust <= magic1 ? 2'd1 : ((ust == 2'd1 && magic2) ? 2'd2 : 2'd0);
      else
        ust <= 2'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_i) begin
      pre1 <= '0;
      pre2 <= '0;
    end else begin
      if (wr_pre1 && open_w) pre1 <= wdata[PRE_W-1:0];
      if (wr_pre2 && open_w) pre2 <= wdata[PRE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst_i || !en || reload) begin
      pcnt  <= '0;
      cnt   <= pre1;
      stage <= 1'b0;
    end else begin
      if (tick_en) pcnt <= pcnt + 1'b1;
      if (tick) begin
        if (cnt <= PRE_W'(1)) begin
          stage <= !stage;
          cnt   <= stage ? pre1 : pre2;
        end else
          cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_i) int_flag <= 1'b0;
    else if (s1_exp && cfg_it != 2'b11) int_flag <= 1'b1;
    else if (wr_stat && wdata[0]) int_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!por_n) tflag <= 1'b0;
    else if (s2_exp && wd_mode) tflag <= 1'b1;
    else if (rld_acc && wdata[9]) tflag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst_i) rst_req <= 1'b0;
    else rst_req <= s2_exp && wd_mode && !cfg_rst;
  end

  always_ff @(posedge clk) begin
    if (rst_i) {cfg_rst, cfg_fast, cfg_it} <= '0;
    else if (wr_cfg) {cfg_rst, cfg_fast, cfg_it} <= {wdata[5], wdata[2], wdata[1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst_i) {mode, en, lk} <= '0;
    else if (wr_lock && !lk) {mode, en, lk} <= wdata[2:0];
  end

  assign irq = int_flag;

  always_comb begin
    case (addr)
      8'h00:   rdata = 32'(pre1);
      8'h04:   rdata = 32'(pre2);
      8'h08:   rdata = {31'd0, int_flag};
      8'h0C:   rdata = {22'd0, tflag, 9'd0};
      8'h10:   rdata = {26'd0, cfg_rst, 2'b00, cfg_fast, cfg_it};
      8'h14:   rdata = {29'd0, mode, en, lk};
      default: rdata = 32'd0;
    endcase
  end

  a_r9_rst_one_cycle: assert property (@(posedge clk) disable iff (rst_i)
    rst_req |=> !rst_req);
  a_r2_pre1_guarded: assert property (@(posedge clk) disable iff (rst_i)
    (wr_pre1 && !open_w) |=> $stable(pre1));
  a_r12_lock_sticky: assert property (@(posedge clk) disable iff (rst_i)
    lk |=> (lk && en == $past(en)));
  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (tflag && !(rld_acc && wdata[9])) |=> tflag);
  a_r8_irq_on_expiry: assert property (@(posedge clk) disable iff (rst_i)
    (s1_exp && cfg_it != 2'b11) |=> irq);
  a_r10_rst_masked: assert property (@(posedge clk) disable iff (rst_i)
    (cfg_rst && !wr_cfg) |=> !rst_req);
  a_r13_timer_no_flag: assert property (@(posedge clk) disable iff (rst_i)
    (mode && !tflag && !(wr_lock && !lk)) |=> !tflag);
endmodule

// File: tb/wdog2s_bench.sv
`timescale 1ns/100ps
module wdog2s_bench;
  logic clk = 1'b0;
  logic por_n = 1'b0, sys_rst_n = 1'b1, tick_en = 1'b1, wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic irq, rst_req;
  int checks = 0, fails = 0, cyc = 0;
  logic done = 1'b0;

  wdog2s #(.PRE_W(20), .SLOW_LOG2(3), .FAST_LOG2(1)) u_wdog2s (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .tick_en(tick_en),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq(irq), .rst_req(rst_req));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // {preload1[7:0], preload2[7:0], fast, int_type[1:0]}
  localparam logic [18:0] VEC [4] = '{
    {8'd3, 8'd2, 1'b0, 2'd0},
    {8'd1, 8'd4, 1'b1, 2'd2},
    {8'd5, 8'd1, 1'b0, 2'd3},
    {8'd0, 8'd0, 1'b1, 2'd1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pw(input logic [7:0] a, input logic [31:0] d);
    wr(8'h0C, 32'h80);
    wr(8'h0C, 32'h86);
    wr(a, d);
  endtask

  task automatic por_pulse();
    @(negedge clk) por_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) por_n = 1'b1;
  endtask

  task automatic mon(input int e, input int n, output int irq_at, output int rst_at, output int rst_cnt);
    irq_at = -1; rst_at = -1; rst_cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq && irq_at < 0) irq_at = cyc - e;
      if (rst_req) begin
        if (rst_at < 0) rst_at = cyc - e;
        rst_cnt++;
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int e, r, ia, ra, rc;
    repeat (3) @(posedge clk);
    @(negedge clk) por_n = 1'b1;

    for (int a = 0; a <= 20; a += 4) begin
      rd(8'(a), v); check("R1 reset register", v, 32'd0);
    end
    check("R1 irq at reset", {31'd0, irq}, 32'd0);
    check("R1 rst_req at reset", {31'd0, rst_req}, 32'd0);

    wr(8'h00, 32'd5); rd(8'h00, v); check("R2 unguarded write ignored", v, 32'd0);

    pw(8'h00, 32'd7); wr(8'h04, 32'd9);
    rd(8'h00, v); check("R3 unlocked write accepted", v, 32'd7);
    rd(8'h04, v); check("R3 second write refused", v, 32'd0);

    wr(8'h0C, 32'h80); wr(8'h10, 32'd0); wr(8'h0C, 32'h86); wr(8'h00, 32'd3);
    rd(8'h00, v); check("R4 cancel by other register", v, 32'd7);
    wr(8'h0C, 32'h80); wr(8'h0C, 32'h81); wr(8'h0C, 32'h86); wr(8'h00, 32'd3);
    rd(8'h00, v); check("R4 cancel by wrong magic", v, 32'd7);

    pw(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); check("R5 preload width", v, 32'h000F_FFFF);

    for (int k = 0; k < 4; k++) begin
      int p1, p2, dv, x_irq, x_rst;
      por_pulse();
      if (k > 0) begin rd(8'h0C, v); check("R11 por clears flag", v, 32'd0); end
      p1 = int'(VEC[k][18:11]); p2 = int'(VEC[k][10:3]);
      dv = VEC[k][2] ? 2 : 8;
      x_irq = (VEC[k][1:0] == 2'd3) ? -1 : dv * (p1 == 0 ? 1 : p1);
      x_rst = dv * ((p1 == 0 ? 1 : p1) + (p2 == 0 ? 1 : p2));
      wr(8'h10, {29'd0, VEC[k][2:0]});
      pw(8'h00, 32'(p1)); pw(8'h04, 32'(p2));
      wr(8'h14, 32'd2); e = cyc;
      mon(e, x_rst + 2, ia, ra, rc);
      check("R7 R8 stage-1 expiry cycle", 32'(ia), 32'(x_irq));
      check("R7 R9 stage-2 reset cycle", 32'(ra), 32'(x_rst));
      check("R9 single-cycle reset", 32'(rc), 32'd1);
      rd(8'h0C, v); check("R9 timeout flag", v, 32'h200);
    end

    @(negedge clk) sys_rst_n = 1'b0;
    @(posedge clk); @(negedge clk) sys_rst_n = 1'b1;
    rd(8'h0C, v); check("R11 flag survives system reset", v, 32'h200);
    pw(8'h0C, 32'h200); rd(8'h0C, v); check("R11 flag cleared by write", v, 32'd0);

    por_pulse();
    wr(8'h10, 32'd4); pw(8'h00, 32'd3); pw(8'h04, 32'd2);
    wr(8'h14, 32'd2);
    repeat (5) pw(8'h0C, 32'h100);
    r = cyc;
    check("R6 keep-alive holds off expiry", {31'd0, irq}, 32'd0);
    wait (cyc == r + 3); pw(8'h0C, 32'h100);
    @(negedge clk); check("R6 restart beats coincident expiry", {31'd0, irq}, 32'd0);
    wait (cyc == r + 11); @(negedge clk);
    check("R6 no expiry before new period", {31'd0, irq}, 32'd0);
    @(negedge clk); check("R6 expiry one period after restart", {31'd0, irq}, 32'd1);

    por_pulse();
    wr(8'h10, 32'd4); pw(8'h00, 32'd3); pw(8'h04, 32'd20);
    wr(8'h14, 32'd2); e = cyc;
    wait (cyc == e + 5); wr(8'h08, 32'd1);
    @(negedge clk); check("R8 set beats coincident clear", {31'd0, irq}, 32'd1);
    wr(8'h08, 32'd1); rd(8'h08, v); check("R8 status cleared", v, 32'd0);
    check("R8 irq cleared", {31'd0, irq}, 32'd0);

    por_pulse();
    wr(8'h10, 32'h24); pw(8'h00, 32'd1); pw(8'h04, 32'd1);
    wr(8'h14, 32'd2); e = cyc;
    mon(e, 8, ia, ra, rc);
    check("R10 reset request suppressed", 32'(rc), 32'd0);
    rd(8'h0C, v); check("R10 flag still set", v, 32'h200);

    por_pulse();
    wr(8'h10, 32'd4); pw(8'h00, 32'd1); pw(8'h04, 32'd1);
    wr(8'h14, 32'd6); e = cyc;
    mon(e, 12, ia, ra, rc);
    check("R13 timer mode no reset", 32'(rc), 32'd0);
    check("R13 timer mode stage-1 still fires", 32'(ia), 32'd2);
    rd(8'h0C, v); check("R13 timer mode no flag", v, 32'd0);

    por_pulse();
    wr(8'h14, 32'd3); wr(8'h14, 32'd0);
    rd(8'h14, v); check("R12 lock keeps enable", v, 32'd3);
    por_pulse();
    rd(8'h14, v); check("R12 reset releases lock", v, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule